// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the clocked, half-duplex shift mode of a serial port. It drives a shift clock on one pin and moves eight data bits, least significant first, over a single data pin. A transmit write while idle sends the byte out. Holding receive enabled while the receive flag is clear clocks a byte in. When the eighth bit finishes, the transmit or receive flag is raised. The host must clear it.

All timing counts ticks of an oscillator-rate enable, `osc_en_i`. A bit cell lasts 12 ticks. The shift clock is low for the first 10 ticks of a cell and high for the last 2. Output data changes only at a cell boundary, so it is set up 10 ticks before each rising clock edge and held 2 ticks after it. Receive data is captured exactly at the rising edge.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk_o` and `sd_o` are 1, `sd_oe_o` is 0, and both flags and `rx_data_o` are 0. Whenever the port is idle, `sclk_o`=1, `sd_o`=1 and `sd_oe_o`=0.
- R2: A `tx_wr_i` pulse while idle starts a transmit on the next cycle. `sd_oe_o`=1 and `sd_o` carries bit k of `tx_data_i` during bit cell k, for k=0..7 (bit 0 first).
- R3: A bit cell is 12 enabled ticks long. In cell phase p (0..11, counted in ticks since the cell began), `sclk_o` is 0 for p<10 and 1 for p>=10.
- R4: During a transmit, `sd_o` changes only at a cell boundary. It is therefore stable through the 10 ticks before each rising clock edge and the 2 ticks after it.
- R5: Cycles with `osc_en_i`=0 do not advance the port. `sclk_o` and `sd_o` hold their values.
- R6: `tx_flag_o` becomes 1 on the 96th tick after the transmit start, and the port returns to idle.
- R7: A `tx_wr_i` pulse while a transfer is active is ignored. The bits already in progress are sent unchanged.
- R8: In an idle cycle, a receive starts when `rx_en_i`=1, `rx_flag_o`=0 and `tx_wr_i`=0. If `tx_wr_i` is also 1 in that cycle, the transmit starts instead. During a receive, `sd_oe_o`=0.
- R9: On a receive, `sd_i` is sampled on the tick where `sclk_o` rises (phase 9 to 10), bit 0 first, with no hold time needed. `rx_flag_o` becomes 1 on the 96th tick.
- R10: `rx_data_o` changes only at the moment `rx_flag_o` is set. Before that it keeps the previous byte.
- R11: Each flag stays 1 until its clear input (`tx_clr_i` or `rx_clr_i`) is pulsed.
- R12: While `rx_flag_o`=1, no receive starts, even with `rx_en_i` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Oscillator-rate tick enable |
| tx_wr_i | input | 1 | Transmit byte write strobe |
| tx_data_i | input | 8 | Byte to transmit |
| rx_en_i | input | 1 | Receive enable |
| tx_clr_i | input | 1 | Clear transmit-done flag |
| rx_clr_i | input | 1 | Clear receive-done flag |
| sd_i | input | 1 | Serial data pin input |
| sd_o | output | 1 | Serial data pin output value |
| sd_oe_o | output | 1 | Serial data pin output enable |
| sclk_o | output | 1 | Shift clock |
| tx_flag_o | output | 1 | Transmit complete |
| rx_flag_o | output | 1 | Receive complete |
| rx_data_o | output | 8 | Last received byte |

## Verification
- A phase counter that is off by one moves the rising edge of `sclk_o` by one tick, and this shows within the first bit cell.
- A wrong bit counter or shift order shows up as a wrong bit on `sd_o` at the following rising edge, or as a flag that rises early or late by a whole cell.
- A receive that samples in the wrong tick picks up the inverted value that is driven right after the edge. This corrupts `rx_data_o`, which becomes visible when the flag rises 96 ticks later.
- Bad state or flag logic appears at the ports right away:
  - a restart while the flag is set shows as clock activity in the very next cell;
  - a write that is not ignored shows as changed data at the next edge.

// File: rtl/ssport_pkg.sv
package ssport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } ssport_state_e;
endpackage

// File: rtl/ssport_bit_timer.sv
module ssport_bit_timer #(
  parameter int CELL_TICKS = 12,
  parameter int HOLD_TICKS = 2,
  parameter int BITS       = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic run_i,
  output logic sample_o,
  output logic cell_end_o,
  output logic last_bit_o,
  output logic sclk_o
);
  localparam int PW = (CELL_TICKS > 1) ? $clog2(CELL_TICKS) : 1;
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int RISE_AT = CELL_TICKS - HOLD_TICKS;
  localparam logic [PW-1:0] PH_LAST = PW'(CELL_TICKS - 1);
  localparam logic [PW-1:0] PH_RISE = PW'(RISE_AT);
  localparam logic [PW-1:0] PH_PRE  = PW'(RISE_AT - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS - 1);

  logic [PW-1:0] phase_q;
  logic [BW-1:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      bit_q   <= '0;
    end else if (start_i) begin
      phase_q <= '0;
      bit_q   <= '0;
    end else if (run_i && tick_i) begin
      if (phase_q == PH_LAST) begin
        phase_q <= '0;
        bit_q   <= bit_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  // sample on the tick that takes the clock high
  assign sample_o   = run_i && tick_i && (phase_q == PH_PRE);
  assign cell_end_o = run_i && tick_i && (phase_q == PH_LAST);
  assign last_bit_o = (bit_q == BIT_LAST);
  assign sclk_o     = !(run_i && (phase_q < PH_RISE));

  p_phase_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= PH_LAST);

  p_sclk_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start_i) |=> $stable(sclk_o));
endmodule

// File: rtl/ssport_shifter.sv
module ssport_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BITS-1:0] load_data_i,
  input  logic            shift_out_i,
  input  logic            shift_in_i,
  input  logic            sd_i,
  output logic [BITS-1:0] data_o,
  output logic            lsb_o
);
  logic [BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sh_q <= '0;
    else if (load_i)      sh_q <= load_data_i;
    else if (shift_out_i) sh_q <= {1'b1, sh_q[BITS-1:1]};
    else if (shift_in_i)  sh_q <= {sd_i, sh_q[BITS-1:1]};
  end

  assign data_o = sh_q;
  assign lsb_o  = sh_q[0];
endmodule

// File: rtl/ssport_ctrl.sv
module ssport_ctrl
  import ssport_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_wr_i,
  input  logic            rx_en_i,
  input  logic            tx_clr_i,
  input  logic            rx_clr_i,
  input  logic            cell_end_i,
  input  logic            last_bit_i,
  input  logic [BITS-1:0] shreg_i,
  output ssport_state_e   state_o,
  output logic            start_tx_o,
  output logic            start_rx_o,
  output logic            tx_flag_o,
  output logic            rx_flag_o,
  output logic [BITS-1:0] rx_buf_o
);
  ssport_state_e   state_q;
  logic            tx_flag_q, rx_flag_q;
  logic [BITS-1:0] rx_buf_q;
  logic            done;

  assign done       = cell_end_i && last_bit_i;
  assign start_tx_o = (state_q == ST_IDLE) && tx_wr_i;
  assign start_rx_o = (state_q == ST_IDLE) && !tx_wr_i && rx_en_i && !rx_flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_tx_o) state_q <= ST_TX;
                 else if (start_rx_o) state_q <= ST_RX;
        ST_TX, ST_RX: if (done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_flag_q <= 1'b0;
      rx_flag_q <= 1'b0;
      rx_buf_q  <= '0;
    end else begin
      if (state_q == ST_TX && done) tx_flag_q <= 1'b1;
      else if (tx_clr_i)            tx_flag_q <= 1'b0;
      if (state_q == ST_RX && done) begin
        rx_flag_q <= 1'b1;
        rx_buf_q  <= shreg_i;
      end else if (rx_clr_i) begin
        rx_flag_q <= 1'b0;
      end
    end
  end

  assign state_o   = state_q;
  assign tx_flag_o = tx_flag_q;
  assign rx_flag_o = rx_flag_q;
  assign rx_buf_o  = rx_buf_q;

  p_tx_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flag_q && !tx_clr_i) |=> tx_flag_q);

  p_rx_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flag_q && !rx_clr_i) |=> rx_flag_q);

  p_no_rx_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flag_q |-> (state_q != ST_RX));

  p_buf_on_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(rx_flag_q) |-> $stable(rx_buf_q));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssport_pkg::*;
#(
  parameter int CELL_TICKS = 12,
  parameter int HOLD_TICKS = 2,
  parameter int BITS       = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            osc_en_i,
  input  logic            tx_wr_i,
  input  logic [BITS-1:0] tx_data_i,
  input  logic            rx_en_i,
  input  logic            tx_clr_i,
  input  logic            rx_clr_i,
  input  logic            sd_i,
  output logic            sd_o,
  output logic            sd_oe_o,
  output logic            sclk_o,
  output logic            tx_flag_o,
  output logic            rx_flag_o,
  output logic [BITS-1:0] rx_data_o
);
  ssport_state_e   state;
  logic            start_tx, start_rx, run;
  logic            sample, cell_end, last_bit;
  logic [BITS-1:0] shreg;
  logic            lsb;

  assign run = (state != ST_IDLE);

  ssport_bit_timer #(
    .CELL_TICKS(CELL_TICKS), .HOLD_TICKS(HOLD_TICKS), .BITS(BITS)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(osc_en_i),
    .start_i(start_tx || start_rx), .run_i(run),
    .sample_o(sample), .cell_end_o(cell_end), .last_bit_o(last_bit),
    .sclk_o(sclk_o)
  );

  ssport_shifter #(.BITS(BITS)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(start_tx), .load_data_i(tx_data_i),
    .shift_out_i(cell_end && state == ST_TX),
    .shift_in_i(sample && state == ST_RX),
    .sd_i(sd_i), .data_o(shreg), .lsb_o(lsb)
  );

  ssport_ctrl #(.BITS(BITS)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_wr_i(tx_wr_i), .rx_en_i(rx_en_i),
    .tx_clr_i(tx_clr_i), .rx_clr_i(rx_clr_i),
    .cell_end_i(cell_end), .last_bit_i(last_bit), .shreg_i(shreg),
    .state_o(state), .start_tx_o(start_tx), .start_rx_o(start_rx),
    .tx_flag_o(tx_flag_o), .rx_flag_o(rx_flag_o), .rx_buf_o(rx_data_o)
  );

  assign sd_oe_o = (state == ST_TX);
  assign sd_o    = sd_oe_o ? lsb : 1'b1;

  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (sclk_o && sd_o && !sd_oe_o));

  p_data_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o && !cell_end) |=> $stable(sd_o));

  p_write_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tx_wr_i && !cell_end) |=> ($stable(sd_o) && $stable(state)));
endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CELL = 12;
  localparam int RISE = 10;
  localparam int TOTAL = 8 * CELL;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_en_i = 1'b0, tx_wr_i = 1'b0, rx_en_i = 1'b0;
  logic tx_clr_i = 1'b0, rx_clr_i = 1'b0, sd_i = 1'b1;
  logic [7:0] tx_data_i = 8'h00;
  logic sd_o, sd_oe_o, sclk_o, tx_flag_o, rx_flag_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_shift_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .osc_en_i(osc_en_i),
    .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i), .rx_en_i(rx_en_i),
    .tx_clr_i(tx_clr_i), .rx_clr_i(rx_clr_i), .sd_i(sd_i),
    .sd_o(sd_o), .sd_oe_o(sd_oe_o), .sclk_o(sclk_o),
    .tx_flag_o(tx_flag_o), .rx_flag_o(rx_flag_o), .rx_data_o(rx_data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp_v, $time);
    end
  endtask

  // one enabled tick followed by one disabled cycle
  task automatic tick();
    osc_en_i = 1'b1;
    @(posedge clk); #1;
    osc_en_i = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic pulse_clr(input bit is_rx);
    if (is_rx) rx_clr_i = 1'b1; else tx_clr_i = 1'b1;
    @(posedge clk); #1;
    rx_clr_i = 1'b0; tx_clr_i = 1'b0;
  endtask

  task automatic run_tx(input logic [7:0] b, input bit poke, input bit with_rx);
    logic exp_clk, exp_sd;
    tx_data_i = b;
    tx_wr_i   = 1'b1;
    if (with_rx) rx_en_i = 1'b1;
    @(posedge clk); #1;
    tx_wr_i = 1'b0;
    rx_en_i = 1'b0;
    if (with_rx) check(sd_oe_o == 1'b1, "R8", sd_oe_o, 1);
    for (int t = 0; t <= TOTAL; t++) begin
      if (t > 0) tick();
      if (t < TOTAL) begin
        exp_clk = ((t % CELL) < RISE) ? 1'b0 : 1'b1;
        exp_sd  = b[t / CELL];
        check(sclk_o == exp_clk, "R3", sclk_o, exp_clk);
        check(sd_o == exp_sd, ((t % CELL) >= RISE) ? "R4" : "R2", sd_o, exp_sd);
        check(sd_oe_o == 1'b1, "R2", sd_oe_o, 1);
        check(tx_flag_o == 1'b0, "R6", tx_flag_o, 0);
        if (poke && t == 30) begin
          tx_data_i = ~b;
          tx_wr_i   = 1'b1;
          @(posedge clk); #1;
          tx_wr_i = 1'b0;
          repeat (20) @(posedge clk);
          #1;
          check(sd_o == exp_sd, "R7", sd_o, exp_sd);
          check(sclk_o == exp_clk, "R5", sclk_o, exp_clk);
        end
      end else begin
        check(sclk_o == 1'b1, "R6", sclk_o, 1);
        check(sd_o == 1'b1 && sd_oe_o == 1'b0, "R6", {sd_o, sd_oe_o}, 2);
        check(tx_flag_o == 1'b1, "R6", tx_flag_o, 1);
      end
    end
    repeat (5) @(posedge clk);
    #1;
    check(tx_flag_o == 1'b1, "R11", tx_flag_o, 1);
    pulse_clr(1'b0);
    check(tx_flag_o == 1'b0, "R11", tx_flag_o, 0);
  endtask

  task automatic run_rx(input logic [7:0] b, input logic [7:0] prev);
    logic exp_clk;
    sd_i    = b[0];
    rx_en_i = 1'b1;
    @(posedge clk); #1;
    for (int t = 0; t <= TOTAL; t++) begin
      if (t > 0) tick();
      if (t < TOTAL) begin
        // new bit at cell start, inverted right after the sampling edge
        if ((t % CELL) == 0)    sd_i = b[t / CELL];
        if ((t % CELL) == RISE) sd_i = ~b[t / CELL];
        exp_clk = ((t % CELL) < RISE) ? 1'b0 : 1'b1;
        check(sclk_o == exp_clk, "R3", sclk_o, exp_clk);
        check(sd_oe_o == 1'b0 && sd_o == 1'b1, "R8", {sd_oe_o, sd_o}, 1);
        check(rx_data_o == prev, "R10", rx_data_o, prev);
        check(rx_flag_o == 1'b0, "R9", rx_flag_o, 0);
      end else begin
        check(rx_flag_o == 1'b1, "R9", rx_flag_o, 1);
        check(rx_data_o == b, "R9", rx_data_o, b);
        check(sclk_o == 1'b1, "R1", sclk_o, 1);
      end
    end
    for (int k = 0; k < 2 * CELL; k++) begin
      tick();
      check(sclk_o == 1'b1, "R12", sclk_o, 1);
    end
    check(rx_data_o == b && rx_flag_o == 1'b1, "R12", rx_data_o, b);
    rx_en_i = 1'b0;
    pulse_clr(1'b1);
    check(rx_flag_o == 1'b0, "R11", rx_flag_o, 0);
  endtask

  initial begin
    logic [7:0] prev;
    repeat (3) @(posedge clk);
    #1;
    check(sclk_o == 1'b1 && sd_o == 1'b1, "R1", {sclk_o, sd_o}, 3);
    check(sd_oe_o == 1'b0, "R1", sd_oe_o, 0);
    check(tx_flag_o == 1'b0 && rx_flag_o == 1'b0, "R1", {tx_flag_o, rx_flag_o}, 0);
    check(rx_data_o == 8'h00, "R1", rx_data_o, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < 256; i++) run_tx(8'(i), 1'b0, 1'b0);
    run_tx(8'h3C, 1'b1, 1'b0);
    run_tx(8'h96, 1'b0, 1'b1);

    prev = 8'h00;
    for (int i = 0; i < 256; i++) begin
      run_rx(8'(i ^ 8'h5A), prev);
      prev = 8'(i ^ 8'h5A);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule